// File: doc/BRIEF.md
# Transaction Contention and Fallback Arbiter

This block settles conflicts between pairs of running transactions and picks the execution mode each aborted transaction uses next. A conflict request names two transactions, A and B. For each it gives an identifier, a flag that says whether it runs in software mode, and an age stamp. One cycle later the block reports which of the two must abort.

Abort reports come in separately. Each one carries the identifier of the aborted transaction and a 3-bit cause code. The block keeps a mode bit and a transient-abort counter for every transaction. One cycle after the report it returns the mode the transaction should use for its next attempt, together with the updated counter. A commit report returns the transaction to its starting state.

The age stamp is the time the transaction started, so a lower value means an older transaction. The cause codes are: 0 contention, 1 page fault and 2 floating-point fault, which are transient; 3 capacity overflow, 4 I/O, 5 system call, 6 non-transient exception and 7 reserved, which are persistent.

Top module: `txn_arbiter`

## Requirements
- R1: When both parties run in the same mode and their age stamps differ, the party with the larger age stamp (the younger one) is reported as the loser.
- R2: When exactly one party runs in software mode, the hardware-mode party loses, whatever the ages.
- R3: When both parties run in the same mode with equal age stamps, the party with the higher identifier loses.
- R4: `loser_valid` is high exactly in the cycle after a cycle with `cfl_valid` high. In that cycle `loser_id` gives the losing identifier and `loser_is_a` is 1 when the loser is party A.
- R5: After reset every transaction is in hardware mode with a counter of 0, and both valid outputs are low.
- R6: An abort with a persistent cause (codes 3 to 7) reported for a hardware-mode transaction moves it to software mode (`dec_sw`=1) at once and leaves its counter unchanged.
- R7: An abort with a transient cause (codes 0 to 2) reported for a hardware-mode transaction increments its counter. The decision stays hardware mode while the counter is below RETRY_LIMIT (default 4) and switches to software mode when the counter reaches it.
- R8: A transaction in software mode stays in software mode on any further abort, and its counter does not change.
- R9: A commit report returns the transaction to hardware mode with its counter cleared.
- R10: `dec_valid` is high exactly in the cycle after a cycle with `abt_valid` high. In that cycle `dec_id` echoes the aborted identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfl_valid | input | 1 | Conflict request present |
| cfl_a_id | input | 3 | Identifier of party A |
| cfl_a_sw | input | 1 | Party A runs in software mode |
| cfl_a_age | input | 16 | Start stamp of party A (lower is older) |
| cfl_b_id | input | 3 | Identifier of party B |
| cfl_b_sw | input | 1 | Party B runs in software mode |
| cfl_b_age | input | 16 | Start stamp of party B |
| loser_valid | output | 1 | Conflict outcome valid |
| loser_id | output | 3 | Identifier of the loser |
| loser_is_a | output | 1 | Loser is party A |
| abt_valid | input | 1 | Abort report present |
| abt_id | input | 3 | Aborted transaction |
| abt_cause | input | 3 | Abort cause code |
| cmt_valid | input | 1 | Commit report present |
| cmt_id | input | 3 | Committed transaction |
| dec_valid | output | 1 | Next-mode decision valid |
| dec_id | output | 3 | Transaction the decision applies to |
| dec_sw | output | 1 | Next attempt runs in software mode |
| dec_retries | output | 3 | Transient-abort count after this abort |

## Verification
The assertions assume that the two parties of a conflict carry different identifiers. They also assume that a commit and an abort never name the same transaction in the same cycle, since the sticky-mode property reads the state as it was before the commit. The random stimulus always draws party B from the identifiers other than A's, and it issues only one report per cycle, so neither case can occur. Age stamps are drawn from a narrow range so that ties and mixed-mode pairs come up often.

// File: rtl/tca_pkg.sv
package tca_pkg;
    typedef enum logic [2:0] {
        CAUSE_CONTENTION = 3'd0,
        CAUSE_PAGE_FAULT = 3'd1,
        CAUSE_FP_FAULT   = 3'd2,
        CAUSE_OVERFLOW   = 3'd3,
        CAUSE_IO         = 3'd4,
        CAUSE_SYSCALL    = 3'd5,
        CAUSE_HARD_EXC   = 3'd6,
        CAUSE_RESERVED   = 3'd7
    } abort_cause_e;

    function automatic logic cause_is_transient(input logic [2:0] c);
        return c <= 3'(CAUSE_FP_FAULT);
    endfunction
endpackage

// File: rtl/tca_conflict_judge.sv
module tca_conflict_judge #(
    parameter int ID_W  = 3,
    parameter int AGE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  a_id,
    input  logic             a_sw,
    input  logic [AGE_W-1:0] a_age,
    input  logic [ID_W-1:0]  b_id,
    input  logic             b_sw,
    input  logic [AGE_W-1:0] b_age,
    output logic             loser_valid,
    output logic [ID_W-1:0]  loser_id,
    output logic             loser_is_a
);
    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic            is_a;
    } judge_t;

    judge_t j_d, j_q;
    logic   a_loses;

    always_comb begin
        if (a_sw != b_sw)       a_loses = !a_sw;
        else if (a_age != b_age) a_loses = a_age > b_age;
        else                    a_loses = a_id > b_id;
        j_d       = '0;
        j_d.valid = req_valid;
        if (req_valid) begin
            j_d.is_a = a_loses;
            j_d.id   = a_loses ? a_id : b_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) j_q <= '0;
        else        j_q <= j_d;
    end

    assign loser_valid = j_q.valid;
    assign loser_id    = j_q.id;
    assign loser_is_a  = j_q.is_a;

    AST_OLDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_sw == b_sw && a_age < b_age) |=> (loser_valid && !loser_is_a)); // R1
    AST_SW_BEATS_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_sw != b_sw) |=> (loser_valid && (loser_is_a == $past(b_sw)))); // R2
    AST_TIE_HIGH_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && a_sw == b_sw && a_age == b_age && a_id != b_id)
        |=> (loser_id == (($past(a_id) > $past(b_id)) ? $past(a_id) : $past(b_id)))); // R3
    AST_OUTCOME_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> loser_valid); // R4
    AST_OUTCOME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !loser_valid); // R4
endmodule

// File: rtl/tca_mode_table.sv
module tca_mode_table
    import tca_pkg::*;
#(
    parameter int NUM_TXN     = 8,
    parameter int RETRY_LIMIT = 4,
    localparam int ID_W  = (NUM_TXN > 1) ? $clog2(NUM_TXN) : 1,
    localparam int CNT_W = $clog2(RETRY_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abt_valid,
    input  logic [ID_W-1:0]  abt_id,
    input  logic [2:0]       abt_cause,
    input  logic             cmt_valid,
    input  logic [ID_W-1:0]  cmt_id,
    output logic             dec_valid,
    output logic [ID_W-1:0]  dec_id,
    output logic             dec_sw,
    output logic [CNT_W-1:0] dec_retries
);
    typedef struct packed {
        logic [NUM_TXN-1:0]            sw;
        logic [NUM_TXN-1:0][CNT_W-1:0] cnt;
        logic                          dvalid;
        logic [ID_W-1:0]               did;
        logic                          dsw;
        logic [CNT_W-1:0]              dcnt;
    } table_t;

    table_t s_d, s_q;
    logic             cur_sw, nxt_sw;
    logic [CNT_W-1:0] cur_cnt, nxt_cnt;

    always_comb begin
        s_d        = s_q;
        s_d.dvalid = abt_valid;
        s_d.did    = abt_id;
        s_d.dsw    = 1'b0;
        s_d.dcnt   = '0;
        cur_sw     = s_q.sw[abt_id];
        cur_cnt    = s_q.cnt[abt_id];
        nxt_sw     = cur_sw;
        nxt_cnt    = cur_cnt;
        if (!cur_sw) begin
            if (cause_is_transient(abt_cause)) begin
                nxt_cnt = cur_cnt + 1'b1;
                if (nxt_cnt >= CNT_W'(RETRY_LIMIT)) nxt_sw = 1'b1;
            end else begin
                nxt_sw = 1'b1;
            end
        end
        if (cmt_valid) begin
            s_d.sw[cmt_id]  = 1'b0;
            s_d.cnt[cmt_id] = '0;
        end
        if (abt_valid) begin
            s_d.sw[abt_id]  = nxt_sw;
            s_d.cnt[abt_id] = nxt_cnt;
            s_d.dsw         = nxt_sw;
            s_d.dcnt        = nxt_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dec_valid   = s_q.dvalid;
    assign dec_id      = s_q.did;
    assign dec_sw      = s_q.dsw;
    assign dec_retries = s_q.dcnt;

    AST_PERSIST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_valid && !cause_is_transient(abt_cause)) |=> (dec_valid && dec_sw)); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_retries <= CNT_W'(RETRY_LIMIT))); // R7
    AST_LIMIT_FORCES_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_retries == CNT_W'(RETRY_LIMIT)) |-> dec_sw); // R7
    AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_valid && s_q.sw[abt_id]) |=> dec_sw); // R8
    AST_DECISION_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid |=> (dec_valid && dec_id == $past(abt_id))); // R10
    AST_DECISION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !abt_valid |=> !dec_valid); // R10
endmodule

// File: rtl/txn_arbiter.sv
module txn_arbiter #(
    parameter int NUM_TXN     = 8,
    parameter int AGE_W       = 16,
    parameter int RETRY_LIMIT = 4,
    localparam int ID_W  = (NUM_TXN > 1) ? $clog2(NUM_TXN) : 1,
    localparam int CNT_W = $clog2(RETRY_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfl_valid,
    input  logic [ID_W-1:0]  cfl_a_id,
    input  logic             cfl_a_sw,
    input  logic [AGE_W-1:0] cfl_a_age,
    input  logic [ID_W-1:0]  cfl_b_id,
    input  logic             cfl_b_sw,
    input  logic [AGE_W-1:0] cfl_b_age,
    output logic             loser_valid,
    output logic [ID_W-1:0]  loser_id,
    output logic             loser_is_a,
    input  logic             abt_valid,
    input  logic [ID_W-1:0]  abt_id,
    input  logic [2:0]       abt_cause,
    input  logic             cmt_valid,
    input  logic [ID_W-1:0]  cmt_id,
    output logic             dec_valid,
    output logic [ID_W-1:0]  dec_id,
    output logic             dec_sw,
    output logic [CNT_W-1:0] dec_retries
);
    tca_conflict_judge #(.ID_W(ID_W), .AGE_W(AGE_W)) i_judge (
        .clk(clk), .rst_n(rst_n), .req_valid(cfl_valid),
        .a_id(cfl_a_id), .a_sw(cfl_a_sw), .a_age(cfl_a_age),
        .b_id(cfl_b_id), .b_sw(cfl_b_sw), .b_age(cfl_b_age),
        .loser_valid(loser_valid), .loser_id(loser_id), .loser_is_a(loser_is_a)
    );

    tca_mode_table #(.NUM_TXN(NUM_TXN), .RETRY_LIMIT(RETRY_LIMIT)) i_table (
        .clk(clk), .rst_n(rst_n),
        .abt_valid(abt_valid), .abt_id(abt_id), .abt_cause(abt_cause),
        .cmt_valid(cmt_valid), .cmt_id(cmt_id),
        .dec_valid(dec_valid), .dec_id(dec_id), .dec_sw(dec_sw),
        .dec_retries(dec_retries)
    );
endmodule

// File: tb/test_txn_arbiter.sv
module test_txn_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int LIM = 4;

    logic clk = 0, rst_n = 0;
    logic cfl_valid = 0, cfl_a_sw = 0, cfl_b_sw = 0;
    logic [2:0] cfl_a_id = 0, cfl_b_id = 0;
    logic [15:0] cfl_a_age = 0, cfl_b_age = 0;
    logic loser_valid, loser_is_a;
    logic [2:0] loser_id;
    logic abt_valid = 0, cmt_valid = 0;
    logic [2:0] abt_id = 0, abt_cause = 0, cmt_id = 0;
    logic dec_valid, dec_sw;
    logic [2:0] dec_id, dec_retries;

    int n_tests = 0, n_fail = 0;
    logic m_sw [N];
    int   m_cnt [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_arbiter i_txn_arbiter (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_a_loses(input logic asw, input logic bsw, input int aage,
                                         input int bage, input int aid, input int bid);
        if (asw != bsw) return !asw;          // R2
        if (aage != bage) return aage > bage; // R1
        return aid > bid;                     // R3
    endfunction

    task automatic conflict(input int aid, input int bid, input logic asw, input logic bsw,
                            input int aage, input int bage);
        logic el;
        el = exp_a_loses(asw, bsw, aage, bage, aid, bid);
        cfl_valid = 1; cfl_a_id = 3'(aid); cfl_b_id = 3'(bid);
        cfl_a_sw = asw; cfl_b_sw = bsw; cfl_a_age = 16'(aage); cfl_b_age = 16'(bage);
        @(negedge clk);
        cfl_valid = 0;
        check(loser_valid, "R4 valid", int'(loser_valid), 1);
        check(loser_is_a == el, (asw != bsw) ? "R2 side" : (aage != bage) ? "R1 side" : "R3 side",
              int'(loser_is_a), int'(el));
        check(loser_id == 3'(el ? aid : bid), "R4 id", int'(loser_id), el ? aid : bid);
    endtask

    task automatic abort(input int id, input int cause);
        if (!m_sw[id]) begin
            if (cause <= 2) begin
                m_cnt[id]++;
                if (m_cnt[id] >= LIM) m_sw[id] = 1;
            end else m_sw[id] = 1;
        end
        abt_valid = 1; abt_id = 3'(id); abt_cause = 3'(cause);
        @(negedge clk);
        abt_valid = 0;
        check(dec_valid && dec_id == 3'(id), "R10 valid/id", int'(dec_id), id);
        check(dec_sw == m_sw[id], (cause <= 2) ? "R7 mode" : "R6 mode", int'(dec_sw), int'(m_sw[id]));
        check(int'(dec_retries) == m_cnt[id], "R8 count", int'(dec_retries), m_cnt[id]);
    endtask

    task automatic commit(input int id);
        m_sw[id] = 0; m_cnt[id] = 0;
        cmt_valid = 1; cmt_id = 3'(id);
        @(negedge clk);
        cmt_valid = 0;
    endtask

    task automatic idle_check();
        @(negedge clk);
        check(!loser_valid, "R4 quiet", int'(loser_valid), 0);
        check(!dec_valid, "R10 quiet", int'(dec_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < N; i++) begin m_sw[i] = 0; m_cnt[i] = 0; end
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check(!loser_valid && !dec_valid, "R5 reset valids", int'(loser_valid | dec_valid), 0);
        rst_n = 1;
        @(negedge clk);
        // R5: a fresh transaction is hardware with count 0, so one transient abort gives count 1
        abort(1, 0);
        check(dec_sw == 0 && dec_retries == 1, "R5 initial state", int'(dec_retries), 1);
        // R1/R2/R3 directed
        conflict(2, 3, 0, 0, 10, 20);
        conflict(2, 3, 1, 1, 30, 20);
        conflict(4, 6, 0, 1, 5, 900);
        conflict(4, 6, 1, 0, 900, 5);
        conflict(7, 2, 0, 0, 8, 8);
        conflict(1, 5, 1, 1, 8, 8);
        idle_check();
        // R7: limit on transaction 5
        for (int k = 0; k < LIM; k++) abort(5, k % 3);
        check(dec_sw == 1 && dec_retries == 3'(LIM), "R7 limit", int'(dec_retries), LIM);
        // R8: sticky
        abort(5, 0);
        abort(5, 4);
        check(dec_sw == 1, "R8 sticky", int'(dec_sw), 1);
        // R9: commit clears
        commit(5);
        abort(5, 2);
        check(dec_sw == 0 && dec_retries == 1, "R9 cleared", int'(dec_retries), 1);
        // R6: persistent on fresh transaction
        abort(6, 5);
        check(dec_sw == 1 && dec_retries == 0, "R6 immediate", int'(dec_retries), 0);
        idle_check();
        // random mix
        for (int it = 0; it < 600; it++) begin
            int op, a, b;
            op = $urandom_range(0, 9);
            a  = $urandom_range(0, N-1);
            if (op < 4) begin
                b = (a + $urandom_range(1, N-1)) % N;
                conflict(a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                         $urandom_range(0, 3), $urandom_range(0, 3));
            end else if (op < 8) abort(a, $urandom_range(0, 7));
            else if (op < 9) commit(a);
            else idle_check();
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule